// File: doc/BRIEF.md
# Multichannel PWM Engine with Selectable 12/16-bit Resolution

The engine drives a bank of channel enables from one shared free-running period counter. Each channel compares a phase derived from that counter with its own brightness word. The channel is on while the phase is below the brightness. A per-channel switch vector gates every output. A resolution select shortens the period from 65536 to 4096 counter steps. A stagger control can shift each channel's turn-on by a fixed number of cycles per channel index, so that the channels do not all switch on together.

Brightness words and the two mode controls are held in an active copy. That copy is refreshed only on the first cycle after reset and on the last cycle of each period, so a period is never cut short or distorted by a mid-period write. The switch vector is not shadowed. It gates the outputs in the same cycle it changes. Brightness words are `FULL_W` bits wide, one word per channel, with channel k at bits [k*FULL_W +: FULL_W].

Top module: `pwm_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `ch_on` bit is 0. The first period starts with the counter at 0 on the cycle after reset is released.
- R2: With `cfg_res12` = 0 the period is 65536 cycles, and the full 16-bit brightness word is compared (0x8000 gives 32768 on-cycles, 0x0800 gives 2048).
- R3: With `cfg_res12` = 1 the period is 4096 cycles, and only brightness bits [11:0] are compared (0xF800 behaves as 0x0800, 0x8000 behaves as 0, 0xFFFF gives 4095 on-cycles).
- R4: A channel is on exactly while its switch bit is 1 and its phase is below its active brightness. In 12-bit mode, 0x0800 gives 2048 on-cycles per period.
- R5: A channel with switch bit 0 or brightness 0 stays off. A switch bit takes effect on `ch_on` in the same cycle it changes.
- R6: In 16-bit mode a brightness of 0xFFFF with the switch on gives 65535 on-cycles out of 65536.
- R7: With `cfg_no_stagger` = 0, channel k's on-window begins k*STEP_CYC cycles after the period starts, wrapping modulo the period. With `cfg_no_stagger` = 1, every window begins at the period start.
- R8: Brightness words, `cfg_res12` and `cfg_no_stagger` are captured only in the first cycle after reset and in the last cycle of a period. A change made mid-period has no effect until the next period.
- R9: A resolution change requested during a period lets that period finish at its old length. The new length applies from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock; the counter advances once per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| bright_words | input | NUM_CH*FULL_W | Brightness word per channel, channel k at [k*FULL_W +: FULL_W] |
| sw_en | input | NUM_CH | Per-channel output switch, 1 = channel allowed on |
| cfg_res12 | input | 1 | 1 = 4096-step period, 0 = 65536-step period |
| cfg_no_stagger | input | 1 | 1 = no per-channel turn-on delay, 0 = delay of k*STEP_CYC |
| ch_on | output | NUM_CH | Channel enables |

## Verification
Two things can happen in the same cycle: a shadow refresh at the period's last cycle, and an input change made mid-period. The bench provokes this by rewriting brightness, and separately the resolution select, a few hundred cycles into a period. It judges the result by counting on-cycles across the whole period, which must match the old settings, and across the next period, which must match the new ones. The switch vector overlaps with the comparison in the same way. The bench clears a switch bit while a channel is inside its on-window and checks that the output drops before the next clock edge. A behavioural model compares every channel on every cycle.

// File: rtl/pwm_pkg.sv
// Shared types and constants for the multichannel PWM engine.
// Assumes the counter is never narrower than the short mode.
package pwm_pkg;

    // Active mode captured at each period boundary
    typedef struct packed {
        logic res12;      // 1 = short period in use
        logic no_stagger; // 1 = channels start together
    } pwm_mode_t;

    localparam int unsigned PWM_DEF_FULL_W  = 16;
    localparam int unsigned PWM_DEF_SHORT_W = 12;

endpackage

// File: rtl/pwm_timebase.sv
// Free-running period counter shared by every channel.
// Counts 0..2^SHORT_W-1 in short mode or 0..2^FULL_W-1 otherwise,
// holds at 0 for one cycle after reset, and flags when the active
// settings may be reloaded. Assumes res12 only changes when load is high.
module pwm_timebase #(
    parameter int unsigned FULL_W  = 16,
    parameter int unsigned SHORT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res12,
    output logic [FULL_W-1:0] cnt,
    output logic              load
);
    localparam logic [FULL_W-1:0] ONE       = FULL_W'(1);
    localparam logic [FULL_W-1:0] SHORT_TOP = FULL_W'((64'd1 << SHORT_W) - 64'd1);

    logic fresh;
    logic at_end;

    // Last count of the current period for the active resolution
    assign at_end = res12 ? (cnt == SHORT_TOP) : (cnt == '1);
    assign load   = fresh | at_end;

    // Advance, wrap or hold the counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
            if (fresh) begin
                cnt <= cnt;
            end else if (at_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + ONE;
            end
        end
    end

    // R3: short mode never sees a count beyond its range
    a_r3_short_range: assert property (@(posedge clk) disable iff (!rst_n)
        res12 |-> (cnt <= SHORT_TOP));

    // R2: between boundaries the count steps by one
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt == $past(cnt) + ONE));

    // R9: a period boundary always restarts from zero
    a_r9_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !fresh) |=> (cnt == '0));

endmodule

// File: rtl/pwm_shadow.sv
// Active copy of brightness words and mode bits.
// Captures the inputs only when load is high, so a period always runs
// with one consistent set of settings. Reset clears to all-off, 16-bit.
module pwm_shadow
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned FULL_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [NUM_CH*FULL_W-1:0] bright_in,
    input  logic                     res12_in,
    input  logic                     no_stagger_in,
    output logic [NUM_CH*FULL_W-1:0] bright_act,
    output pwm_mode_t                mode_act
);
    // Capture settings at reset-exit or period end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bright_act <= '0;
            mode_act   <= '0;
        end else if (load) begin
            bright_act          <= bright_in;
            mode_act.res12      <= res12_in;
            mode_act.no_stagger <= no_stagger_in;
        end
    end

    // R8: active settings hold between boundaries
    a_r8_hold_between_loads: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(bright_act) && $stable(mode_act)));

endmodule

// File: rtl/pwm_channel.sv
// One PWM output: compares the channel phase with its brightness.
// The phase is the shared count minus OFFSET (when staggering), wrapped
// to the active period; only the active period's bits are compared.
module pwm_channel #(
    parameter int unsigned FULL_W  = 16,
    parameter int unsigned SHORT_W = 12,
    parameter int unsigned OFFSET  = 0
) (
    input  logic [FULL_W-1:0] cnt,
    input  logic              res12,
    input  logic              no_stagger,
    input  logic [FULL_W-1:0] bright,
    input  logic              sw_bit,
    output logic              on
);
    localparam logic [FULL_W-1:0] OFF_V      = FULL_W'(OFFSET);
    localparam logic [FULL_W-1:0] SHORT_MASK = FULL_W'((64'd1 << SHORT_W) - 64'd1);

    logic [FULL_W-1:0] phase;
    logic [FULL_W-1:0] mask;

    // Phase within the period and the compare window for this channel
    always_comb begin
        mask  = res12 ? SHORT_MASK : '1;
        phase = (cnt - (no_stagger ? '0 : OFF_V)) & mask;
        on    = sw_bit & (phase < (bright & mask));
    end

endmodule

// File: rtl/pwm_engine.sv
// Multichannel PWM engine top: one shared counter, a shadow of the
// settings, and NUM_CH comparators with per-index turn-on offset.
// Assumes the switch vector is synchronous to clk.
module pwm_engine
    import pwm_pkg::*;
#(
    parameter int unsigned NUM_CH   = 16,
    parameter int unsigned FULL_W   = PWM_DEF_FULL_W,
    parameter int unsigned SHORT_W  = PWM_DEF_SHORT_W,
    parameter int unsigned STEP_CYC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*FULL_W-1:0] bright_words,
    input  logic [NUM_CH-1:0]        sw_en,
    input  logic                     cfg_res12,
    input  logic                     cfg_no_stagger,
    output logic [NUM_CH-1:0]        ch_on
);
    logic [FULL_W-1:0]        cnt;
    logic                     load;
    logic [NUM_CH*FULL_W-1:0] bright_act;
    pwm_mode_t                mode_act;

    pwm_timebase #(.FULL_W(FULL_W), .SHORT_W(SHORT_W)) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .res12 (mode_act.res12),
        .cnt   (cnt),
        .load  (load)
    );

    pwm_shadow #(.NUM_CH(NUM_CH), .FULL_W(FULL_W)) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .bright_in     (bright_words),
        .res12_in      (cfg_res12),
        .no_stagger_in (cfg_no_stagger),
        .bright_act    (bright_act),
        .mode_act      (mode_act)
    );

    // One comparator per channel, offset grows with channel index
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(
            .FULL_W  (FULL_W),
            .SHORT_W (SHORT_W),
            .OFFSET  (g * STEP_CYC)
        ) u_ch (
            .cnt        (cnt),
            .res12      (mode_act.res12),
            .no_stagger (mode_act.no_stagger),
            .bright     (bright_act[g*FULL_W +: FULL_W]),
            .sw_bit     (sw_en[g]),
            .on         (ch_on[g])
        );
    end

    // R1: outputs are idle right after a reset cycle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (ch_on == '0));

    // R5: no output is on while its switch is off
    a_r5_switch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_on & ~sw_en) == '0));

endmodule

// File: tb/test_pwm_engine.sv
`timescale 1ns/1ps
// Bench for pwm_engine: behavioural reference model checked every cycle,
// plus period-level on-time counts for each requirement.
module test_pwm_engine;
    localparam int NUM_CH = 16;
    localparam int FULL_W = 16;
    localparam int STEP   = 4;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH*FULL_W-1:0] bright_words = '0;
    logic [NUM_CH-1:0]        sw_en = '1;
    logic                     cfg_res12 = 1'b1;
    logic                     cfg_no_stagger = 1'b1;
    logic [NUM_CH-1:0]        ch_on;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit done = 0;

    pwm_engine #(.NUM_CH(NUM_CH), .FULL_W(FULL_W), .SHORT_W(12), .STEP_CYC(STEP)) i_pwm_engine (
        .clk(clk), .rst_n(rst_n), .bright_words(bright_words), .sw_en(sw_en),
        .cfg_res12(cfg_res12), .cfg_no_stagger(cfg_no_stagger), .ch_on(ch_on)
    );

    always #10 clk = ~clk;

    // Reference model state
    int m_cnt = 0;
    bit m_fresh = 1;
    bit m_short = 0;
    bit m_nostag = 0;
    int m_br [NUM_CH];

    always @(posedge clk) begin
        int term;
        bit ld;
        if (!rst_n) begin
            m_cnt = 0; m_fresh = 1; m_short = 0; m_nostag = 0;
            for (int c = 0; c < NUM_CH; c++) m_br[c] = 0;
        end else begin
            term = m_short ? 4095 : 65535;
            ld = m_fresh || (m_cnt == term);
            if (!m_fresh) m_cnt = (m_cnt == term) ? 0 : m_cnt + 1;
            if (ld) begin
                m_short = cfg_res12;
                m_nostag = cfg_no_stagger;
                for (int c = 0; c < NUM_CH; c++) m_br[c] = int'(bright_words[c*FULL_W +: FULL_W]);
            end
            m_fresh = 0;
        end
    end

    function automatic bit exp_on(int ch);
        int p, off, ph, b;
        p = m_short ? 4096 : 65536;
        off = m_nostag ? 0 : ch * STEP;
        ph = ((m_cnt - off) % p + p) % p;
        b = m_br[ch] % p;
        return sw_en[ch] && (ph < b);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R4, R7)
    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            int bad = -1;
            for (int c = 0; c < NUM_CH; c++)
                if (ch_on[c] !== exp_on(c) && bad < 0) bad = c;
            if (bad >= 0) chk(0, $sformatf("R4 model ch%0d", bad), int'(ch_on[bad]), int'(exp_on(bad)));
            else chk(1, "R4", 0, 0);
        end
    end

    // Period measurement
    int on_cnt [NUM_CH];
    int first_on [NUM_CH];
    bit last_on [NUM_CH];
    int idx = 0;

    task automatic clear_meas();
        idx = 0;
        for (int c = 0; c < NUM_CH; c++) begin on_cnt[c] = 0; first_on[c] = -1; end
    endtask

    task automatic measure(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #3;
            for (int c = 0; c < NUM_CH; c++) begin
                last_on[c] = ch_on[c];
                if (ch_on[c] === 1'b1) begin
                    if (first_on[c] < 0) first_on[c] = idx;
                    on_cnt[c]++;
                end
            end
            idx++;
        end
    endtask

    task automatic set_br(input int ch, input int v);
        bright_words[ch*FULL_W +: FULL_W] = FULL_W'(v);
    endtask

    initial begin
        #(195000 * 20);
        errors++;
        $display("FAIL R1 watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_br(0, 16'h0800); set_br(1, 0); set_br(2, 16'hF800); set_br(3, 16'h0FFF);
        set_br(4, 16'h0400);
        for (int c = 5; c < NUM_CH; c++) set_br(c, c * 256);
        sw_en = '1; sw_en[4] = 1'b0;
        repeat (3) @(negedge clk);
        cmp_en = 1;
        #3 chk(ch_on == '0, "R1 in reset", int'(ch_on), 0);
        @(negedge clk); #3 chk(ch_on == '0, "R1 in reset", int'(ch_on), 0);
        rst_n = 1'b1;

        // Period 1: 12-bit, no stagger
        clear_meas(); measure(4096);
        chk(first_on[0] == 0, "R1 first period starts at 0", first_on[0], 0);
        chk(on_cnt[0] == 2048, "R4 0x0800 12-bit", on_cnt[0], 2048);
        chk(on_cnt[1] == 0, "R5 zero brightness", on_cnt[1], 0);
        chk(on_cnt[2] == 2048, "R3 upper bits ignored", on_cnt[2], 2048);
        chk(on_cnt[3] == 4095, "R3 0x0FFF", on_cnt[3], 4095);
        chk(on_cnt[4] == 0, "R5 switch off", on_cnt[4], 0);
        chk(on_cnt[5] == 1280, "R4 0x0500", on_cnt[5], 1280);

        // Period 2: mid-period brightness change held off
        clear_meas(); measure(100);
        set_br(0, 16'h0100);
        measure(3996);
        chk(on_cnt[0] == 2048, "R8 mid-period write ignored", on_cnt[0], 2048);

        // Period 3: new brightness applied; switch acts at once
        clear_meas(); measure(11);
        sw_en[0] = 1'b0;
        #1 chk(ch_on[0] == 1'b0, "R5 switch same cycle", int'(ch_on[0]), 0);
        measure(5);
        sw_en[0] = 1'b1;
        measure(4080);
        chk(on_cnt[0] == 251, "R8 applied next period", on_cnt[0], 251);
        cfg_no_stagger = 1'b0;
        sw_en = '1;
        for (int c = 0; c < NUM_CH; c++) set_br(c, 16'h0010);

        // Period 4: staggered starts
        clear_meas(); measure(4096);
        for (int c = 0; c < NUM_CH; c++) begin
            chk(first_on[c] == c * STEP, $sformatf("R7 start ch%0d", c), first_on[c], c * STEP);
            chk(on_cnt[c] == 16, $sformatf("R7 width ch%0d", c), on_cnt[c], 16);
        end
        cfg_res12 = 1'b0; cfg_no_stagger = 1'b1;
        for (int c = 0; c < NUM_CH; c++) set_br(c, 0);
        set_br(0, 16'hFFFF); set_br(1, 16'h8000); set_br(2, 16'h0800);

        // Period 5: 16-bit, resolution change requested mid-period
        clear_meas(); measure(1000);
        cfg_res12 = 1'b1;
        measure(64536);
        chk(on_cnt[0] == 65535, "R6 full scale 16-bit", on_cnt[0], 65535);
        chk(last_on[0] == 1'b0, "R6 last cycle off", int'(last_on[0]), 0);
        chk(on_cnt[1] == 32768, "R2 0x8000 16-bit", on_cnt[1], 32768);
        chk(on_cnt[2] == 2048, "R9 old length kept", on_cnt[2], 2048);

        // Period 6: 12-bit now in force
        clear_meas(); measure(4096);
        chk(on_cnt[0] == 4095, "R3 0xFFFF in 12-bit", on_cnt[0], 4095);
        chk(on_cnt[1] == 0, "R3 0x8000 in 12-bit", on_cnt[1], 0);
        chk(on_cnt[2] == 2048, "R9 new length", on_cnt[2], 2048);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule